// File: doc/BRIEF.md
# Backplane Bus Master Interface

This block turns single-cycle requests from a local processor into complete, handshaked transfers on an asynchronous backplane. The backplane has 8 data bits and 20 address bits, which covers a 1 MiB memory space plus a separate I/O space. The local side presents an address, write data, a memory-or-I/O select and a read-or-write select, then pulses a start strobe. When the transfer is over the block answers with a one-cycle done pulse, an error flag and, for reads, the captured read data.

On the bus side the block drives the address, the write data with its output enable, and a three-bit cycle-type code. It also drives an active-low address strobe and an active-low data strobe, which always move together. It then stretches the cycle with wait states until the slave answers. The slave answers on one of two active-low lines: one reports success and the other reports a failed transfer. A programmable timeout ends a cycle that no slave answers. After each cycle the block waits until both response lines have gone inactive before it starts another cycle.

The interface is clocked from the bus reference clock (nominally 16 MHz). The slave response lines are sampled directly on that clock.

Top module: `bkp_master`

## Requirements
- R1: While reset is held and after it is released, dat_stb_n and adr_stb_n are 1, rsp_done, rsp_err and bus_wdata_oe are 0, bus_cm is 3'b111 and rsp_rdata is 0.
- R2: bus_cm is {1, req_mem, req_rd}. This gives 111 for a memory read, 110 for a memory write, 101 for an I/O read and 100 for an I/O write. The codes 011, 010, 001 and 000 are never driven.
- R3: adr_stb_n and dat_stb_n assert in the same cycle and release in the same cycle.
- R4: bus_addr, bus_cm and bus_wdata are loaded on the edge that accepts req_start. The strobes assert one cycle later, and these outputs stay stable while the strobes are asserted. bus_wdata_oe is 1 only for writes, from acceptance until the strobes release.
- R5: The strobes remain asserted until an asserted dat_ack_n or trf_err_n is sampled. Waiting k extra edges for the response keeps the strobes low for k+1 cycles. rsp_done pulses for exactly one cycle, on the edge on which the strobes release.
- R6: On the edge where dat_ack_n is sampled low during a read, rsp_rdata takes bus_rdata and rsp_err is 0. A write leaves rsp_rdata unchanged.
- R7: When trf_err_n is sampled low, the transfer ends with rsp_err = 1 and rsp_rdata unchanged. If both response lines are low on the same edge, the error wins.
- R8: If no response is sampled within cfg_timeout strobe-low clock edges (cfg_timeout >= 1), the strobes release and the transfer ends with rsp_err = 1. A response sampled on the last of those edges still counts.
- R9: After release, the strobes do not assert again until both dat_ack_n and trf_err_n have been sampled high. A req_start arriving while a transfer is in progress is ignored.
- R10: rsp_err holds its value from one done pulse until the next done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_timeout | input | TW | Number of strobe-low edges before timeout (>= 1) |
| req_start | input | 1 | Start a transfer (accepted only when idle) |
| req_addr | input | AW | Transfer address |
| req_wdata | input | DW | Write data |
| req_mem | input | 1 | 1 = memory space, 0 = I/O space |
| req_rd | input | 1 | 1 = read, 0 = write |
| rsp_rdata | output | DW | Last successfully read byte |
| rsp_done | output | 1 | One-cycle transfer-finished pulse |
| rsp_err | output | 1 | Last transfer failed (slave error or timeout) |
| bus_addr | output | AW | Backplane address |
| bus_wdata | output | DW | Backplane write data |
| bus_wdata_oe | output | 1 | Write data output enable |
| bus_rdata | input | DW | Backplane read data |
| bus_cm | output | 3 | Cycle-type code |
| adr_stb_n | output | 1 | Address strobe, active low |
| dat_stb_n | output | 1 | Data strobe, active low |
| dat_ack_n | input | 1 | Slave success acknowledge, active low |
| trf_err_n | input | 1 | Slave transfer error, active low |

## Verification
Two of this block's functions can land on the same clock edge in two ways. A slave response can arrive on the final edge of the timeout window, and a success acknowledge can arrive together with a transfer error. The bench's slave model provokes the first case by answering exactly cfg_timeout-1 edges after the strobe assertion, and once more one edge later. The scoreboard expects success (with the new read data) in the first case and a timeout error in the second. It provokes the second case by driving both lines low together and expects an error with the previous read data kept.

// File: rtl/bkp_master.sv
module bkp_master #(
  parameter int AW = 20,
  parameter int DW = 8,
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] cfg_timeout,
  input  logic          req_start,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          req_mem,
  input  logic          req_rd,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_done,
  output logic          rsp_err,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  output logic          bus_wdata_oe,
  input  logic [DW-1:0] bus_rdata,
  output logic [2:0]    bus_cm,
  output logic          adr_stb_n,
  output logic          dat_stb_n,
  input  logic          dat_ack_n,
  input  logic          trf_err_n
);

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_WAIT, S_RECOV} st_t;

  st_t           st;
  logic [TW-1:0] cnt;
  logic          stb;

  wire got_ack  = !dat_ack_n;
  wire got_err  = !trf_err_n;
  wire tmo_last = (cnt == cfg_timeout - TW'(1));
  wire finish   = got_ack || got_err || tmo_last;

  assign adr_stb_n = !stb;
  assign dat_stb_n = !stb;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      cnt          <= '0;
      stb          <= 1'b0;
      bus_addr     <= '0;
      bus_wdata    <= '0;
      bus_wdata_oe <= 1'b0;
      bus_cm       <= 3'b111;
      rsp_rdata    <= '0;
      rsp_done     <= 1'b0;
      rsp_err      <= 1'b0;
    end else begin
      rsp_done <= 1'b0;
      case (st)
        S_IDLE: if (req_start) begin
          bus_addr     <= req_addr;
          bus_wdata    <= req_wdata;
          bus_wdata_oe <= !req_rd;
          bus_cm       <= {1'b1, req_mem, req_rd};
          st           <= S_SETUP;
        end
        S_SETUP: begin
          stb <= 1'b1;
          cnt <= '0;
          st  <= S_WAIT;
        end
        S_WAIT: if (finish) begin
          stb          <= 1'b0;
          bus_wdata_oe <= 1'b0;
          rsp_done     <= 1'b1;
          rsp_err      <= got_err || !got_ack;
          if (got_ack && !got_err && bus_cm[0]) rsp_rdata <= bus_rdata;
          st           <= S_RECOV;
        end else begin
          cnt <= cnt + TW'(1);
        end
        S_RECOV: if (!got_ack && !got_err) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  p_cm_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cm[2] == 1'b1);

  p_setup_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dat_stb_n) |-> $stable(bus_addr) && $stable(bus_cm) && $stable(bus_wdata));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!dat_stb_n && $past(!dat_stb_n)) |-> $stable(bus_addr) && $stable(bus_cm)
                                         && $stable(bus_wdata) && $stable(bus_wdata_oe));

  p_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!dat_stb_n && dat_ack_n && trf_err_n && !tmo_last) |=> !dat_stb_n);

  p_done_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> dat_stb_n && $past(!dat_stb_n));

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  p_keep_rdata_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && rsp_err) |-> $stable(rsp_rdata));

  p_slave_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!dat_stb_n && !trf_err_n) |=> rsp_done && rsp_err);

  p_timeout_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!dat_stb_n && tmo_last && dat_ack_n && trf_err_n) |=> rsp_done && rsp_err);

  p_recover_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dat_stb_n) |-> $past(dat_ack_n) && $past(trf_err_n));

  p_err_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_done |-> $stable(rsp_err));

endmodule

// File: tb/sim_bkp_master.sv
module sim_bkp_master;
  localparam int TMO = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] cfg_timeout = 12'(TMO);
  logic        req_start = 1'b0;
  logic [19:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_mem = 1'b0, req_rd = 1'b0;
  logic [7:0]  rsp_rdata;
  logic        rsp_done, rsp_err;
  logic [19:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic        bus_wdata_oe;
  logic [7:0]  bus_rdata = 8'hEE;
  logic [2:0]  bus_cm;
  logic        adr_stb_n, dat_stb_n;
  logic        dat_ack_n = 1'b1, trf_err_n = 1'b1;

  always #2.5 clk = ~clk;

  bkp_master u0 (.*);

  int n_chk = 0, n_bad = 0, n_done = 0, n_cyc = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected transaction state shared with slave model
  logic [19:0] e_addr;
  logic [7:0]  e_wd, model_rd = 8'h00;
  logic [2:0]  e_cm;
  logic        e_rd, e_err;
  int          s_mode, s_delay, s_hold, e_len;
  logic [7:0]  s_rval;
  logic [8:0]  exp_q[$];

  // slave model: drives responses at negedge, master samples next posedge
  int scnt = 0, hcnt = 0;
  bit was_low = 0, driving = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      n_cyc++;
      if (!dat_stb_n) begin
        if (scnt == 0) begin
          chk(dat_ack_n && trf_err_n, "R9 response idle at strobe", {dat_ack_n, trf_err_n}, 3);
          chk(adr_stb_n == dat_stb_n, "R3 strobes assert together", adr_stb_n, dat_stb_n);
          chk(bus_addr == e_addr, "R4 address", bus_addr, e_addr);
          chk(bus_cm == e_cm, "R2 cycle code", bus_cm, e_cm);
          chk(bus_wdata_oe == !e_rd, "R4 data enable", bus_wdata_oe, !e_rd);
          if (!e_rd) chk(bus_wdata == e_wd, "R4 write data", bus_wdata, e_wd);
        end
        if (scnt == s_delay && s_mode != 3) begin
          driving = 1;
          bus_rdata <= s_rval;
          if (s_mode == 0 || s_mode == 2) dat_ack_n <= 1'b0;
          if (s_mode == 1 || s_mode == 2) trf_err_n <= 1'b0;
        end
        scnt++;
        was_low = 1;
      end else begin
        if (was_low) begin
          chk(scnt == e_len, "R5/R8 strobe low length", scnt, e_len);
          chk(adr_stb_n == 1'b1, "R3 strobes release together", adr_stb_n, 1);
          was_low = 0;
          scnt = 0;
          hcnt = s_hold;
        end
        if (driving) begin
          if (hcnt == 0) begin
            driving = 0;
            dat_ack_n <= 1'b1;
            trf_err_n <= 1'b1;
            bus_rdata <= 8'hEE;
          end else hcnt--;
        end
      end
    end
  end

  // monitor: pops the scoreboard at each done pulse
  bit prev_done = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_done) chk(!rsp_done, "R5 done is one cycle", rsp_done, 0);
      if (rsp_done) begin
        logic [8:0] e;
        n_done++;
        chk(dat_stb_n, "R5 release with done", dat_stb_n, 1);
        if (exp_q.size() == 0) chk(0, "R9 unexpected transfer", 1, 0);
        else begin
          e = exp_q.pop_front();
          chk(rsp_err == e[8], "R6/R7/R8 error flag", rsp_err, e[8]);
          chk(rsp_rdata == e[7:0], "R6/R7 read data", rsp_rdata, e[7:0]);
        end
      end
      prev_done = rsp_done;
    end
  end

  task automatic xfer(input logic [19:0] a, input logic [7:0] d, input logic m, input logic r,
                      input int md, input int dl, input int hd, input logic [7:0] rv,
                      input bit stray);
    bit ok;
    int n0, w;
    e_addr = a; e_wd = d; e_cm = {1'b1, m, r}; e_rd = r;
    s_mode = md; s_delay = dl; s_hold = hd; s_rval = rv;
    ok = (md == 0 && dl < TMO);
    e_len = (md == 3 || dl >= TMO) ? TMO : dl + 1;
    if (ok && r) model_rd = rv;
    e_err = !ok;
    exp_q.push_back({!ok, model_rd});
    n0 = n_done;
    @(negedge clk);
    req_addr = a; req_wdata = d; req_mem = m; req_rd = r; req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    if (stray) begin
      repeat (2) @(negedge clk);
      req_addr = a ^ 20'hFFFFF; req_rd = !r; req_start = 1'b1;
      @(negedge clk);
      req_start = 1'b0;
    end
    w = 0;
    while (n_done == n0 && w < 100) begin @(negedge clk); w++; end
    if (w >= 100) chk(0, "R5 transfer never finished", 0, 1);
    repeat (hd + 4) @(negedge clk);
    chk(rsp_err == e_err, "R10 error flag held", rsp_err, e_err);
  endtask

  bit finished = 0;
  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(dat_stb_n && adr_stb_n, "R1 strobes idle in reset", {dat_stb_n, adr_stb_n}, 3);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rsp_done && !rsp_err && !bus_wdata_oe, "R1 flags after reset",
        {rsp_done, rsp_err, bus_wdata_oe}, 0);
    chk(bus_cm == 3'b111 && rsp_rdata == 8'h00, "R1 code and data after reset",
        {bus_cm, rsp_rdata}, {3'b111, 8'h00});
    // R2/R6 memory read, immediate ack
    xfer(20'hABCDE, 8'h00, 1, 1, 0, 0, 0, 8'hA5, 0);
    // R2/R4/R6 memory write with wait states
    xfer(20'h00010, 8'h3C, 1, 0, 0, 3, 0, 8'h77, 0);
    // R2 I/O read and I/O write
    xfer(20'h00F23, 8'h00, 0, 1, 0, 2, 1, 8'h5A, 0);
    xfer(20'h00F24, 8'hC3, 0, 0, 0, 1, 0, 8'h11, 0);
    // R7 slave error on read keeps previous data
    xfer(20'h12345, 8'h00, 1, 1, 1, 2, 0, 8'h99, 0);
    // R7 both responses on same edge: error wins
    xfer(20'h54321, 8'h00, 1, 1, 2, 1, 0, 8'h66, 0);
    // R8 no response at all -> timeout
    xfer(20'hFFFFF, 8'h00, 0, 1, 3, 0, 0, 8'h00, 0);
    // R10 success clears error
    xfer(20'h00001, 8'h00, 1, 1, 0, 0, 0, 8'h42, 0);
    // R8 response on final edge counts, one later is a timeout
    xfer(20'h0AAAA, 8'h00, 1, 1, 0, TMO - 1, 0, 8'hB7, 0);
    xfer(20'h05555, 8'h00, 1, 1, 0, TMO, 0, 8'hC8, 0);
    // R9 slave holds acknowledge long after release, next cycle follows at once
    xfer(20'h00100, 8'h0F, 1, 0, 0, 0, 6, 8'h00, 0);
    xfer(20'h00200, 8'h00, 1, 1, 0, 0, 0, 8'hD4, 0);
    // R9 start while busy is ignored
    xfer(20'h33333, 8'h00, 1, 1, 0, 5, 0, 8'h1E, 1);
    chk(dat_stb_n && bus_addr == 20'h33333, "R9 stray start ignored", bus_addr, 20'h33333);
    chk(exp_q.size() == 0, "R9 no extra transfer", exp_q.size(), 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule